// File: doc/BRIEF.md
# Write Cache Flush Request Register

This block is a single 32-bit memory-mapped control register that lets software ask an attached write cache to flush everything it holds, and then tells software when the flush has finished. Two independent write/read ports reach the register: a local host port and an inbound memory-mapped port. Either one can raise the flush request. Only the cache controller's completion pulse can lower it.

The register's only live field is bit 0. Writing a 1 there while no flush is pending sets the bit. One cycle later the block emits a single-cycle flush-start pulse to the cache controller. The bit stays set until the controller answers with a flush-done pulse, and software polls it to learn that the flush is complete. Writing 1 while the bit is already set changes nothing. This guarantees that at most one flush is outstanding at any time. The cache and its flush algorithm lie outside the block.

Top module: `wc_flush_ctl`

## Requirements
- R1: After a synchronous reset, the request bit is 0 and flush_start is low. Reads on both ports return 0.
- R2: A read at byte address 0x0E0 returns the request bit in bit 0, with bits 31:1 always 0. Read data appears on the port's rdata the cycle after the read is sampled and shows the bit as it stood before that clock edge. Reads at any other address return 0.
- R3: A host-port write to address 0x0E0 with data bit 0 equal to 1 sets an idle request bit.
- R4: An inbound-port write to address 0x0E0 with data bit 0 equal to 1 sets an idle request bit.
- R5: None of the following changes the request bit: a write whose data bit 0 is 0 (whatever bits 31:1 hold), or a write to any address other than 0x0E0.
- R6: A flush_done pulse while the request bit is set clears it at the next clock edge.
- R7: After the bit goes from 0 to 1 at one clock edge, flush_start is high for exactly one cycle, from the following edge. flush_start is never high at any other time.
- R8: A write of 1 while the bit is already set neither changes the bit nor produces another flush_start pulse.
- R9: If both ports write 1 to an idle bit in the same cycle, the bit is set once and exactly one flush_start pulse follows.
- R10: If flush_done and a write of 1 arrive in the same cycle while the bit is set, the bit clears and the write is dropped.
- R11: A flush_done pulse while the bit is clear is ignored. A write of 1 in that same cycle still sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host port write strobe |
| h_rd_en | input | 1 | Host port read strobe |
| h_addr | input | 12 | Host port byte address |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data, registered |
| m_wr_en | input | 1 | Inbound port write strobe |
| m_rd_en | input | 1 | Inbound port read strobe |
| m_addr | input | 12 | Inbound port byte address |
| m_wdata | input | 32 | Inbound port write data |
| m_rdata | output | 32 | Inbound port read data, registered |
| flush_start | output | 1 | Single-cycle flush command to the cache controller |
| flush_done | input | 1 | Completion pulse from the cache controller |

## Verification
The assertions check several rules on every cycle:
- a pending request survives until a done pulse arrives, and a done pulse on a pending request clears it;
- the bit never rises while neither port writes;
- each rise of the bit is followed by exactly one start pulse and no other;
- the reserved read bits stay zero.

Address decode needs the bench's scenarios, which also cover:
- the data-bit-0 rule and the reserved write bits;
- the same-cycle collisions between the two ports, or between a write and a done pulse;
- the rejection of a second write while a flush is pending;
- the ignoring of a spurious done pulse.

Across all of these, a behavioural reference model is compared against both read ports and the start output on every clock.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
  localparam int unsigned WCF_ADDR_W  = 12;
  localparam int unsigned WCF_DATA_W  = 32;
  localparam int unsigned WCF_NPORTS  = 2;
  localparam logic [WCF_ADDR_W-1:0] WCF_REG_OFF = 12'h0E0;

  // port index assignment
  localparam int unsigned WCF_PORT_HOST = 0;
  localparam int unsigned WCF_PORT_MMIO = 1;

  typedef enum logic {
    WCF_IDLE    = 1'b0,
    WCF_PENDING = 1'b1
  } wcf_state_e;
endpackage

// File: rtl/wcf_port_dec.sv
module wcf_port_dec #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFF = '0
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              set_req,
  output logic              rd_hit
);
  logic addr_hit;
  logic unused_rsvd;

  assign addr_hit    = (addr == REG_OFF);
  // only bit 0 is writable; reserved bits are dropped
  assign set_req     = wr_en & addr_hit & wdata[0];
  assign rd_hit      = rd_en & addr_hit;
  assign unused_rsvd = ^wdata[DATA_W-1:1];
endmodule

// File: rtl/wcf_req_bit.sv
module wcf_req_bit
  import wcf_pkg::*;
#(
  parameter int unsigned NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] set_vec,
  input  logic              done,
  output logic              req_q
);
  wcf_state_e state_q, state_d;
  logic       set_any;

  assign set_any = |set_vec;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WCF_IDLE:    if (set_any) state_d = WCF_PENDING;
      // a write arriving while pending is dropped; done wins
      WCF_PENDING: if (done)    state_d = WCF_IDLE;
      default:                  state_d = WCF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= WCF_IDLE;
    else     state_q <= state_d;
  end

  assign req_q = (state_q == WCF_PENDING);
endmodule

// File: rtl/wcf_pulse.sv
module wcf_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      level_d <= level;
      pulse   <= level & ~level_d;
    end
  end
endmodule

// File: rtl/wcf_readback.sv
module wcf_readback #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic              req_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= DATA_W'(req_q);
    else             rdata <= '0;
  end
endmodule

// File: rtl/wc_flush_ctl.sv
module wc_flush_ctl
  import wcf_pkg::*;
#(
  parameter int unsigned ADDR_W = WCF_ADDR_W,
  parameter int unsigned DATA_W = WCF_DATA_W,
  parameter logic [ADDR_W-1:0] REG_OFF = WCF_REG_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              m_wr_en,
  input  logic              m_rd_en,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  output logic              flush_start,
  input  logic              flush_done
);
  localparam int unsigned NP = WCF_NPORTS;

  logic [NP-1:0]     p_wr, p_rd, p_set, p_hit;
  logic [ADDR_W-1:0] p_addr  [NP];
  logic [DATA_W-1:0] p_wdata [NP];
  logic [DATA_W-1:0] p_rdata [NP];
  logic              req_q;

  assign p_wr[WCF_PORT_HOST]    = h_wr_en;
  assign p_rd[WCF_PORT_HOST]    = h_rd_en;
  assign p_addr[WCF_PORT_HOST]  = h_addr;
  assign p_wdata[WCF_PORT_HOST] = h_wdata;
  assign p_wr[WCF_PORT_MMIO]    = m_wr_en;
  assign p_rd[WCF_PORT_MMIO]    = m_rd_en;
  assign p_addr[WCF_PORT_MMIO]  = m_addr;
  assign p_wdata[WCF_PORT_MMIO] = m_wdata;
  assign h_rdata = p_rdata[WCF_PORT_HOST];
  assign m_rdata = p_rdata[WCF_PORT_MMIO];

  for (genvar i = 0; i < NP; i++) begin : g_port
    wcf_port_dec #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_OFF(REG_OFF)
    ) u_dec (
      .wr_en  (p_wr[i]),
      .rd_en  (p_rd[i]),
      .addr   (p_addr[i]),
      .wdata  (p_wdata[i]),
      .set_req(p_set[i]),
      .rd_hit (p_hit[i])
    );

    wcf_readback #(.DATA_W(DATA_W)) u_rb (
      .clk   (clk),
      .rst   (rst),
      .rd_hit(p_hit[i]),
      .req_q (req_q),
      .rdata (p_rdata[i])
    );
  end

  wcf_req_bit #(.NPORTS(NP)) u_req (
    .clk    (clk),
    .rst    (rst),
    .set_vec(p_set),
    .done   (flush_done),
    .req_q  (req_q)
  );

  wcf_pulse u_pls (
    .clk  (clk),
    .rst  (rst),
    .level(req_q),
    .pulse(flush_start)
  );
endmodule

// File: rtl/wcf_checker.sv
module wcf_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_q,
  input logic              flush_start,
  input logic              flush_done,
  input logic              h_wr_en,
  input logic              m_wr_en,
  input logic [DATA_W-1:0] h_rdata,
  input logic [DATA_W-1:0] m_rdata
);
  p_clear_on_done_r6: assert property (@(posedge clk) disable iff (rst)
    req_q && flush_done |=> !req_q);

  p_hold_pending_r8: assert property (@(posedge clk) disable iff (rst)
    req_q && !flush_done |=> req_q);

  p_no_spont_set_r5: assert property (@(posedge clk) disable iff (rst)
    !req_q && !h_wr_en && !m_wr_en |=> !req_q);

  p_start_after_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |=> flush_start);

  p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
    flush_start |=> !flush_start);

  p_start_only_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    flush_start |-> $past(req_q) && !$past(req_q, 2));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    h_rdata[DATA_W-1:1] == '0 && m_rdata[DATA_W-1:1] == '0);
endmodule

bind wc_flush_ctl wcf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_q      (req_q),
  .flush_start(flush_start),
  .flush_done (flush_done),
  .h_wr_en    (h_wr_en),
  .m_wr_en    (m_wr_en),
  .h_rdata    (h_rdata),
  .m_rdata    (m_rdata)
);

// File: tb/sim_wc_flush_ctl.sv
`timescale 1ns/1ps
module sim_wc_flush_ctl;
  localparam int LAT = 4;
  localparam logic [11:0] OFF = 12'h0E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr_en = 0, h_rd_en = 0, m_wr_en = 0, m_rd_en = 0;
  logic [11:0] h_addr = 0, m_addr = 0;
  logic [31:0] h_wdata = 0, m_wdata = 0;
  logic [31:0] h_rdata, m_rdata;
  logic        flush_start;
  logic        flush_done = 0;

  int tests = 0, fails = 0;
  int starts = 0;
  int cnt = 0;
  bit auto_en = 1;
  bit finished = 0;

  // reference model state
  bit          mdl_req = 0;
  longint      cyc = 0, due = -1;
  bit          exp_start = 0;
  logic [31:0] exp_hr = 0, exp_mr = 0;

  always #2 clk = ~clk;

  wc_flush_ctl u0 (
    .clk(clk), .rst(rst),
    .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata),
    .m_wr_en(m_wr_en), .m_rd_en(m_rd_en), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata),
    .flush_start(flush_start), .flush_done(flush_done)
  );

  always @(posedge clk) begin : ref_model
    bit set;
    if (rst) begin
      mdl_req = 0; due = -1; exp_start = 0; exp_hr = 0; exp_mr = 0;
    end else begin
      set = (h_wr_en && h_addr == OFF && h_wdata[0]) ||
            (m_wr_en && m_addr == OFF && m_wdata[0]);
      exp_hr = (h_rd_en && h_addr == OFF) ? {31'b0, mdl_req} : 32'b0;
      exp_mr = (m_rd_en && m_addr == OFF) ? {31'b0, mdl_req} : 32'b0;
      exp_start = (cyc == due);
      if (mdl_req) begin
        if (flush_done) mdl_req = 0;
      end else if (set) begin
        mdl_req = 1;
        due = cyc + 1;
      end
    end
    cyc++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check("R7 start vs model", {31'b0, flush_start}, {31'b0, exp_start});
    check("R2 host rdata vs model", h_rdata, exp_hr);
    check("R2 inbound rdata vs model", m_rdata, exp_mr);
    if (flush_start) starts++;
    h_wr_en = 0; h_rd_en = 0; m_wr_en = 0; m_rd_en = 0; flush_done = 0;
    if (auto_en && flush_start) cnt = LAT;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) flush_done = 1;
    end
  endtask

  task automatic hwrite(logic [11:0] a, logic [31:0] d);
    h_wr_en = 1; h_addr = a; h_wdata = d;
  endtask
  task automatic mwrite(logic [11:0] a, logic [31:0] d);
    m_wr_en = 1; m_addr = a; m_wdata = d;
  endtask
  task automatic hread(logic [11:0] a);
    h_rd_en = 1; h_addr = a;
  endtask
  task automatic mread(logic [11:0] a);
    m_rd_en = 1; m_addr = a;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : stim
    int s0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    hread(OFF); mread(OFF); tick();
    check("R1 host read after reset", h_rdata, 32'h0);
    check("R1 inbound read after reset", m_rdata, 32'h0);
    check("R1 no start after reset", {31'b0, flush_start}, 32'h0);

    // R3 host set, R7 pulse timing, R6 auto clear
    s0 = starts;
    hwrite(OFF, 32'h1); tick();
    check("R7 start low right after write", {31'b0, flush_start}, 32'h0);
    hread(OFF); tick();
    check("R7 start one cycle after bit set", {31'b0, flush_start}, 32'h1);
    hread(OFF); tick();
    check("R3 host write sets bit", h_rdata, 32'h1);
    check("R7 start is single cycle", {31'b0, flush_start}, 32'h0);
    idle(6);
    hread(OFF); tick();
    check("R6 done clears bit", h_rdata, 32'h0);
    check("R7 one pulse per flush", starts - s0, 1);

    // R4 inbound set
    mwrite(OFF, 32'h8000_0001); tick();
    mread(OFF); tick();
    check("R4 inbound write sets bit", m_rdata, 32'h1);
    idle(7);
    mread(OFF); tick();
    check("R6 inbound sees clear", m_rdata, 32'h0);

    // R5 ignored writes
    s0 = starts;
    hwrite(OFF, 32'hFFFF_FFFE); tick();
    mwrite(12'h0E4, 32'h1); tick();
    hwrite(12'h0E1, 32'h1); tick();
    hread(OFF); mread(OFF); tick();
    check("R5 bit0=0 / wrong addr no set (host)", h_rdata, 32'h0);
    check("R5 bit0=0 / wrong addr no set (inbound)", m_rdata, 32'h0);
    idle(2);
    check("R5 no start from ignored writes", starts - s0, 0);

    // R8 rewrite while pending (auto done off)
    auto_en = 0; cnt = 0;
    s0 = starts;
    hwrite(OFF, 32'h1); tick();
    idle(3);
    mwrite(OFF, 32'h1); tick();
    hwrite(OFF, 32'h1); tick();
    idle(3);
    hread(OFF); tick();
    check("R8 bit stays set", h_rdata, 32'h1);
    check("R8 only one start pulse", starts - s0, 1);
    // R2 reads elsewhere return zero while pending
    hread(12'h0E4); mread(12'h000); tick();
    check("R2 host off-address read zero", h_rdata, 32'h0);
    check("R2 inbound off-address read zero", m_rdata, 32'h0);
    flush_done = 1; tick();
    hread(OFF); tick();
    check("R6 forced done clears", h_rdata, 32'h0);

    // R9 both ports together
    s0 = starts;
    hwrite(OFF, 32'h1); mwrite(OFF, 32'h1); tick();
    idle(4);
    mread(OFF); tick();
    check("R9 bit set by dual write", m_rdata, 32'h1);
    check("R9 exactly one start", starts - s0, 1);

    // R10 done and set together while pending
    s0 = starts;
    flush_done = 1; hwrite(OFF, 32'h1); tick();
    hread(OFF); tick();
    check("R10 clear wins over write", h_rdata, 32'h0);
    idle(3);
    check("R10 dropped write gives no start", starts - s0, 0);

    // R11 done while idle
    flush_done = 1; tick();
    hread(OFF); tick();
    check("R11 idle done leaves bit clear", h_rdata, 32'h0);
    s0 = starts;
    flush_done = 1; mwrite(OFF, 32'h1); tick();
    mread(OFF); tick();
    check("R11 write with idle done sets bit", m_rdata, 32'h1);
    idle(2);
    check("R11 start after idle-done write", starts - s0, 1);
    flush_done = 1; tick();
    idle(2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule